// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This controller erases one block of a parallel NOR flash device and then confirms that the block reads back blank. The caller gives a block number and pulses `start`. The controller then runs the whole command sequence on the flash side without further help. It drives a byte-wide command bus and pulses a write-gate line before each protected command. It polls the device status byte at a slow, fixed rate and finally sweeps the block with 32-bit reads. When it finishes, it raises `done` for one cycle together with a two-bit result code.

All delays are counted in milliseconds. A millisecond is `TICK_DIV` clock cycles, set by a prescaler, so a bench can shrink the delays without changing the sequence. The following are all parameters:
- the block size (`2**BLK_W` bytes),
- the settle, poll and pre-verify delays,
- the overall poll timeout,
- the number of attempts.

A failed attempt is repeated from the start of the sequence. The controller stops retrying when `MAX_TRIES` attempts have been made.

The flash side reads with a one-cycle latency. When `fl_rd` is high in a cycle with address `fl_addr`, the device returns the addressed status/data byte on `fl_rbyte` and the addressed 32-bit word on `fl_rword` in the next cycle.

Top module: `flash_blk_eraser`

## Requirements
- R1: During and after reset, with no start given, `busy` and `done` are low and none of `fl_we`, `fl_rd` and `fl_gate` is asserted.
- R2: A `start` seen while idle captures `blk_sel` and raises `busy` in the next cycle. A `start` seen while an operation runs is ignored: it neither changes the block being erased nor produces an extra `done`.
- R3: Each attempt begins with this sequence:
  1. a dummy read at the half-block offset `H = 2**(BLK_W-1)` of the device;
  2. a gate pulse;
  3. the byte 0x50 written to `H`;
  4. a dummy read of the target `T = blk*2**BLK_W + H`;
  5. a gate pulse;
  6. 0x20 written to `T`;
  7. 0xD0 written to `T` in the very next cycle.
- R4: After the 0xD0 write, the first status read of `T` comes `(SETTLE_MS+POLL_MS)*TICK_DIV+1` cycles later. Further status reads follow every `POLL_MS*TICK_DIV+2` cycles until status bit 7 (ready) reads 1. An attempt gives up with result 3 (timeout) once `ceil(TIMEOUT_MS/POLL_MS)` reads have all returned not-ready.
- R5: When polling ends (ready or timed out), the controller writes 0xFF to `T`, directly after a gate pulse. The write comes three cycles after the last status read.
- R6: If the ready status has bit 5 set, the attempt fails with result 1 (device error). In that case 0x50 is written to `H` after the 0xFF write, and no verify reads are made.
- R7: Otherwise, `VERIFY_MS*TICK_DIV+1` cycles after the 0xFF write, the controller reads the block's words at `blk*2**BLK_W + 4*i`, for i ascending from 0, one read every two cycles. It stops at the first word that is not 0xFFFFFFFF, with result 2 (verify error). If all words match, the result is 0 (ok).
- R8: A failed attempt restarts the R3 sequence at once. This repeats until `MAX_TRIES` attempts have been made. The reported code is that of the last attempt, and a success on any attempt reports 0.
- R9: `done` is high for exactly one cycle, and `busy` is low in that cycle. `result` keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an erase of `blk_sel` (taken when idle) |
| blk_sel | input | ADDR_W-BLK_W | Block number to erase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 device error, 2 verify error, 3 timeout |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Command byte |
| fl_we | output | 1 | Command write strobe |
| fl_rd | output | 1 | Read strobe (byte and word) |
| fl_gate | output | 1 | Write-gate open pulse |
| fl_rbyte | input | 8 | Status/data byte, valid the cycle after `fl_rd` |
| fl_rword | input | 32 | Data word, valid the cycle after `fl_rd` |

## Verification
The bench flash model records the clock cycle of every write, read and gate pulse. Expected cycles are then computed from the formulas in the requirements:
- the first status read at `(S+P)*T+1` cycles after the confirm write;
- poll spacing of `P*T+2` cycles;
- the 0xFF write three cycles after the last status read;
- the first verify read `V*T+1` cycles after that write;
- verify reads spaced two cycles apart.

`done` and `result` are sampled on falling edges only. `busy` is checked one edge after `start`, `done` and `result` at the edge where `done` is first seen, and the one-cycle width of `done` and the holding of `result` on the following edge.

// File: rtl/flash_blk_eraser.sv
`timescale 1ns/1ps
module flash_blk_eraser #(
  parameter int ADDR_W     = 22,
  parameter int BLK_W      = 16,
  parameter int TICK_DIV   = 50000,
  parameter int SETTLE_MS  = 10,
  parameter int POLL_MS    = 10,
  parameter int VERIFY_MS  = 10,
  parameter int TIMEOUT_MS = 10000,
  parameter int MAX_TRIES  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-BLK_W-1:0] blk_sel,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              result,
  output logic [ADDR_W-1:0]       fl_addr,
  output logic [7:0]              fl_wdata,
  output logic                    fl_we,
  output logic                    fl_rd,
  output logic                    fl_gate,
  input  logic [7:0]              fl_rbyte,
  input  logic [31:0]             fl_rword
);
  localparam int NB_W  = ADDR_W - BLK_W;
  localparam int WD_W  = BLK_W - 2;
  localparam int MSMAX = (SETTLE_MS > POLL_MS) ? ((SETTLE_MS > VERIFY_MS) ? SETTLE_MS : VERIFY_MS)
                                               : ((POLL_MS > VERIFY_MS) ? POLL_MS : VERIFY_MS);
  localparam int MS_W  = $clog2(MSMAX + 1);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam int ACC_W = $clog2(TIMEOUT_MS + POLL_MS + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  localparam logic [1:0] RES_OK  = 2'd0;
  localparam logic [1:0] RES_DEV = 2'd1;
  localparam logic [1:0] RES_VER = 2'd2;
  localparam logic [1:0] RES_TMO = 2'd3;

  localparam logic [7:0] CMD_CLR   = 8'h50;
  localparam logic [7:0] CMD_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONF  = 8'hD0;
  localparam logic [7:0] CMD_READ  = 8'hFF;

  typedef enum logic [4:0] {
    S_IDLE, S_RD0, S_GATE0, S_CLR, S_RD1, S_GATE1, S_SETUP, S_CONF,
    S_SETTLE, S_PWAIT, S_PRD, S_PCHK, S_GATE2, S_RESTORE, S_CLR2,
    S_VWAIT, S_VRD, S_VCHK, S_FIN
  } st_t;

  st_t              st;
  logic [NB_W-1:0]  blk_r;
  logic [PRE_W-1:0] pre;
  logic [MS_W-1:0]  ms_left;
  logic [ACC_W-1:0] acc;
  logic [TRY_W-1:0] tries;
  logic [WD_W-1:0]  widx;
  logic             timed_out, dev_err;
  logic [1:0]       res_r;

  logic [ADDR_W-1:0] half_a, targ_a, word_a;
  assign half_a = ADDR_W'(1) << (BLK_W - 1);
  assign targ_a = {blk_r, BLK_W'(0)} | half_a;
  assign word_a = {blk_r, widx, 2'b00};

  logic wait_st, tick, wait_end, last_try;
  assign wait_st  = (st == S_SETTLE) || (st == S_PWAIT) || (st == S_VWAIT);
  assign tick     = (pre == PRE_W'(TICK_DIV - 1));
  assign wait_end = wait_st && tick && (ms_left == '0);
  assign last_try = (tries == TRY_W'(MAX_TRIES - 1));

  logic unused_rb;
  assign unused_rb = ^{fl_rbyte[6], fl_rbyte[4:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)              pre <= '0;
    else if (!wait_st || tick) pre <= '0;
    else                     pre <= pre + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      blk_r     <= '0;
      ms_left   <= '0;
      acc       <= '0;
      tries     <= '0;
      widx      <= '0;
      timed_out <= 1'b0;
      dev_err   <= 1'b0;
      res_r     <= RES_OK;
    end else begin
      if (wait_st && tick && ms_left != '0) ms_left <= ms_left - MS_W'(1);
      case (st)
        S_IDLE: if (start) begin
          blk_r <= blk_sel;
          tries <= '0;
          st    <= S_RD0;
        end
        S_RD0:   st <= S_GATE0;
        S_GATE0: st <= S_CLR;
        S_CLR:   st <= S_RD1;
        S_RD1:   st <= S_GATE1;
        S_GATE1: st <= S_SETUP;
        S_SETUP: st <= S_CONF;
        S_CONF: begin
          ms_left <= MS_W'(SETTLE_MS - 1);
          acc     <= '0;
          st      <= S_SETTLE;
        end
        S_SETTLE: if (wait_end) begin
          ms_left <= MS_W'(POLL_MS - 1);
          st      <= S_PWAIT;
        end
        S_PWAIT: if (wait_end) st <= S_PRD;
        S_PRD: begin
          acc <= acc + ACC_W'(POLL_MS);
          st  <= S_PCHK;
        end
        S_PCHK: begin
          if (fl_rbyte[7]) begin
            dev_err   <= fl_rbyte[5];
            timed_out <= 1'b0;
            st        <= S_GATE2;
          end else if (acc >= ACC_W'(TIMEOUT_MS)) begin
            dev_err   <= 1'b0;
            timed_out <= 1'b1;
            st        <= S_GATE2;
          end else begin
            ms_left <= MS_W'(POLL_MS - 1);
            st      <= S_PWAIT;
          end
        end
        S_GATE2: st <= S_RESTORE;
        S_RESTORE: begin
          if (timed_out) begin
            res_r <= RES_TMO;
            if (last_try) st <= S_FIN;
            else begin tries <= tries + TRY_W'(1); st <= S_RD0; end
          end else if (dev_err) begin
            st <= S_CLR2;
          end else begin
            ms_left <= MS_W'(VERIFY_MS - 1);
            widx    <= '0;
            st      <= S_VWAIT;
          end
        end
        S_CLR2: begin
          res_r <= RES_DEV;
          if (last_try) st <= S_FIN;
          else begin tries <= tries + TRY_W'(1); st <= S_RD0; end
        end
        S_VWAIT: if (wait_end) st <= S_VRD;
        S_VRD:   st <= S_VCHK;
        S_VCHK: begin
          if (fl_rword != 32'hFFFF_FFFF) begin
            res_r <= RES_VER;
            if (last_try) st <= S_FIN;
            else begin tries <= tries + TRY_W'(1); st <= S_RD0; end
          end else if (widx == '1) begin
            res_r <= RES_OK;
            st    <= S_FIN;
          end else begin
            widx <= widx + WD_W'(1);
            st   <= S_VRD;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_addr  = '0;
    fl_wdata = '0;
    fl_we    = 1'b0;
    fl_rd    = 1'b0;
    fl_gate  = 1'b0;
    case (st)
      S_RD0:     begin fl_rd = 1'b1; fl_addr = half_a; end
      S_GATE0,
      S_GATE1,
      S_GATE2:   fl_gate = 1'b1;
      S_CLR,
      S_CLR2:    begin fl_we = 1'b1; fl_addr = half_a; fl_wdata = CMD_CLR; end
      S_RD1,
      S_PRD:     begin fl_rd = 1'b1; fl_addr = targ_a; end
      S_SETUP:   begin fl_we = 1'b1; fl_addr = targ_a; fl_wdata = CMD_SETUP; end
      S_CONF:    begin fl_we = 1'b1; fl_addr = targ_a; fl_wdata = CMD_CONF; end
      S_RESTORE: begin fl_we = 1'b1; fl_addr = targ_a; fl_wdata = CMD_READ; end
      S_VRD:     begin fl_rd = 1'b1; fl_addr = word_a; end
      default: ;
    endcase
  end

  assign busy   = (st != S_IDLE) && (st != S_FIN);
  assign done   = (st == S_FIN);
  assign result = res_r;

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_we, fl_rd, fl_gate}));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);

  // R3
  setup_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_wdata == CMD_SETUP) |-> $past(fl_gate));

  // R3
  confirm_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_wdata == CMD_CONF) |->
      ($past(fl_we && fl_wdata == CMD_SETUP) && fl_addr == $past(fl_addr)));

  // R5
  restore_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_wdata == CMD_READ) |-> $past(fl_gate));

  // R7
  verify_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_VCHK && fl_rword != 32'hFFFF_FFFF) |=> (st == S_RD0 || st == S_FIN));

  // R8
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TRY_W'(MAX_TRIES - 1));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));
endmodule

// File: tb/flash_blk_eraser_tb.sv
`timescale 1ns/1ps
module flash_blk_eraser_tb;
  localparam int ADDR_W = 10, BLK_W = 6, TD = 4;
  localparam int SM = 3, PM = 2, VM = 5, TOM = 8, MT = 3;
  localparam int NB_W = ADDR_W - BLK_W;
  localparam int BLK = 1 << BLK_W, H = BLK / 2, NWORD = BLK / 4;
  localparam int NPOLL = (TOM + PM - 1) / PM;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NB_W-1:0] blk_sel = '0;
  logic busy, done, fl_we, fl_rd, fl_gate;
  logic [1:0] result;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0] fl_wdata;
  logic [7:0] fl_rbyte = '0;
  logic [31:0] fl_rword = '0;

  always #2 clk = ~clk;

  flash_blk_eraser #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .TICK_DIV(TD), .SETTLE_MS(SM),
    .POLL_MS(PM), .VERIFY_MS(VM), .TIMEOUT_MS(TOM), .MAX_TRIES(MT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_sel(blk_sel), .busy(busy), .done(done),
    .result(result), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_rd(fl_rd),
    .fl_gate(fl_gate), .fl_rbyte(fl_rbyte), .fl_rword(fl_rword));

  int cyc = 0, gate_last = -10, attempt = 0, sreads = 0;
  bit smode = 0;
  int ready_after = 1, dev_n = 0, to_n = 0, stk_n = 0, stk_idx = 0;
  int wa[4096], wd[4096], wc[4096], wg[4096], ra[4096], rc[4096], rs[4096];
  int nw = 0, nr = 0;
  int nchk = 0, nfail = 0;
  int w0, r0, a0;
  bit all_done = 0;

  always @(posedge clk) begin
    bit rdy;
    cyc <= cyc + 1;
    if (fl_gate) gate_last <= cyc;
    if (fl_we) begin
      wa[nw] <= int'(fl_addr); wd[nw] <= int'(fl_wdata); wc[nw] <= cyc;
      wg[nw] <= (gate_last == cyc - 1) ? 1 : 0;
      nw <= nw + 1;
      if (fl_wdata == 8'hD0) begin smode <= 1; sreads <= 0; attempt <= attempt + 1; end
      if (fl_wdata == 8'hFF) smode <= 0;
    end
    if (fl_rd) begin
      ra[nr] <= int'(fl_addr); rc[nr] <= cyc; rs[nr] <= smode ? 1 : 0;
      nr <= nr + 1;
      if (smode) begin
        sreads <= sreads + 1;
        rdy = (sreads + 1 >= ready_after) && !(attempt - 1 < to_n);
        fl_rbyte <= {rdy, 1'b0, rdy && (attempt - 1 < dev_n), 5'b0};
      end else fl_rbyte <= 8'h00;
      fl_rword <= ((attempt - 1 < stk_n) && int'(fl_addr[BLK_W-1:2]) == stk_idx) ?
                  32'hFFFF_F7FF : 32'hFFFF_FFFF;
    end
  end

  task automatic chk_eq(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int b, output int res);
    int k;
    w0 = nw; r0 = nr; a0 = attempt;
    @(negedge clk); blk_sel = NB_W'(b); start = 1;
    @(negedge clk); start = 0;
    chk_eq("R2 busy after start", int'(busy), 1);
    k = 0;
    while (!done && k < 50000) begin @(negedge clk); k++; end
    chk_eq("R9 done seen", int'(done), 1);
    res = int'(result);
    chk_eq("R9 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk_eq("R9 done one cycle", int'(done), 0);
    chk_eq("R9 result held", int'(result), res);
  endtask

  task automatic check_clean_seq(input int b);
    int t = b * BLK + H;
    chk_eq("R3 clear addr", wa[w0], H);      chk_eq("R3 clear data", wd[w0], 8'h50);
    chk_eq("R3 clear gated", wg[w0], 1);
    chk_eq("R3 setup addr", wa[w0+1], t);    chk_eq("R3 setup data", wd[w0+1], 8'h20);
    chk_eq("R3 setup gated", wg[w0+1], 1);
    chk_eq("R3 confirm addr", wa[w0+2], t);  chk_eq("R3 confirm data", wd[w0+2], 8'hD0);
    chk_eq("R3 confirm next cycle", wc[w0+2], wc[w0+1] + 1);
    chk_eq("R5 restore addr", wa[w0+3], t);  chk_eq("R5 restore data", wd[w0+3], 8'hFF);
    chk_eq("R5 restore gated", wg[w0+3], 1);
    chk_eq("R3 dummy read half", ra[r0], H);
    chk_eq("R3 dummy read target", ra[r0+1], t);
    chk_eq("R3 dummy before clear", int'(rc[r0] < wc[w0]), 1);
  endtask

  initial begin
    int res;
    repeat (3) @(negedge clk);
    chk_eq("R1 busy in reset", int'(busy), 0);
    chk_eq("R1 done in reset", int'(done), 0);
    chk_eq("R1 strobes in reset", int'({fl_we, fl_rd, fl_gate}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk_eq("R1 idle after reset", int'({busy, done, fl_we, fl_rd, fl_gate}), 0);

    // R3 R7: every block, clean erase
    for (int b = 0; b < (1 << NB_W); b++) begin
      run_op(b, res);
      chk_eq("R7 clean result ok", res, 0);
      chk_eq("R3 write count", nw - w0, 4);
      chk_eq("R7 read count", nr - r0, 3 + NWORD);
      check_clean_seq(b);
      for (int i = 0; i < NWORD; i++)
        chk_eq("R7 word addr", ra[r0 + 3 + i], b * BLK + 4 * i);
    end

    // R4 R5 R7 timing
    ready_after = 3;
    run_op(5, res);
    chk_eq("R4 result", res, 0);
    chk_eq("R4 first poll", rc[r0+2], wc[w0+2] + 1 + (SM + PM) * TD);
    chk_eq("R4 poll spacing a", rc[r0+3] - rc[r0+2], PM * TD + 2);
    chk_eq("R4 poll spacing b", rc[r0+4] - rc[r0+3], PM * TD + 2);
    chk_eq("R4 status reads", rs[r0+2] + rs[r0+3] + rs[r0+4], 3);
    chk_eq("R5 restore timing", wc[w0+3], rc[r0+4] + 3);
    chk_eq("R7 first verify timing", rc[r0+5], wc[w0+3] + 1 + VM * TD);
    chk_eq("R7 verify spacing", rc[r0+6] - rc[r0+5], 2);
    chk_eq("R7 first verify addr", ra[r0+5], 5 * BLK);
    ready_after = 1;

    // R4 R8: timeout on every attempt
    to_n = 1000;
    run_op(2, res);
    chk_eq("R4 timeout code", res, 3);
    chk_eq("R8 timeout attempts", attempt - a0, MT);
    chk_eq("R4 reads per timed-out attempt", nr - r0, MT * (2 + NPOLL));
    chk_eq("R5 writes with timeout", nw - w0, MT * 4);
    chk_eq("R5 restore after timeout", wd[w0+3], 8'hFF);
    to_n = 0;

    // R8: timeout twice, success on last allowed attempt
    to_n = attempt + MT - 1;
    run_op(7, res);
    chk_eq("R8 late success", res, 0);
    chk_eq("R8 late success attempts", attempt - a0, MT);
    to_n = 0;

    // R6 R8: device error always
    dev_n = 1000;
    run_op(4, res);
    chk_eq("R6 device error code", res, 1);
    chk_eq("R8 device error attempts", attempt - a0, MT);
    chk_eq("R6 write count", nw - w0, MT * 5);
    chk_eq("R6 clear addr", wa[w0+4], H);
    chk_eq("R6 clear data", wd[w0+4], 8'h50);
    chk_eq("R6 no verify reads", nr - r0, MT * 3);
    dev_n = 0;

    // R6 R8: device error once then ok
    dev_n = attempt + 1;
    run_op(9, res);
    chk_eq("R8 retry after device error", res, 0);
    chk_eq("R8 attempts after one device error", attempt - a0, 2);
    chk_eq("R6 restart clear", wd[w0+5], 8'h50);
    dev_n = 0;

    // R7 R8: stuck word at every index, persistent
    for (int k = 0; k < NWORD; k++) begin
      stk_n = 1000; stk_idx = k;
      run_op(3, res);
      chk_eq("R7 verify error code", res, 2);
      chk_eq("R7 reads stop at mismatch", nr - r0, MT * (4 + k));
      chk_eq("R7 last read addr", ra[nr - 1], 3 * BLK + 4 * k);
      chk_eq("R8 verify attempts", attempt - a0, MT);
    end
    stk_n = 0;

    // R7 R8: stuck last word once
    stk_n = attempt + 1; stk_idx = NWORD - 1;
    run_op(11, res);
    chk_eq("R8 retry after verify error", res, 0);
    chk_eq("R8 verify retry attempts", attempt - a0, 2);
    stk_n = 0;

    // R2: start while busy is ignored
    begin
      int k, ndone;
      w0 = nw; r0 = nr;
      @(negedge clk); blk_sel = NB_W'(6); start = 1;
      @(negedge clk); start = 0;
      repeat (5) @(negedge clk);
      blk_sel = NB_W'(13); start = 1;
      @(negedge clk); start = 0;
      blk_sel = '0;
      k = 0; ndone = 0;
      while (k < 2000) begin @(negedge clk); if (done) ndone++; k++; end
      chk_eq("R2 one done for busy start", ndone, 1);
      chk_eq("R2 ignored start writes", nw - w0, 4);
      chk_eq("R2 block kept", wa[w0+1], 6 * BLK + H);
      chk_eq("R2 verify block kept", ra[nr - 1], 6 * BLK + 4 * (NWORD - 1));
      chk_eq("R9 result held idle", int'(result), 0);
    end

    all_done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!all_done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule